// File: doc/BRIEF.md
# Triggered Multi-Event Buffer Manager

This block takes one channel of continuously sampled data and stores it in an event memory. The memory is split into equal slots. A first-level trigger reserves a free slot. After a fixed latency the block writes the incoming samples into that slot, one per clock, until the slot is full. Only one slot can be waiting or filling at a time.

A second-level decision arrives later for each reserved slot, in trigger order. It either keeps the slot or gives it back to the free pool. Kept slots wait in a queue. Each is then streamed out over a valid/ready port that carries the slot index with every word. The slot is released once its final word has been taken.

The memory geometry is set by a mode input: many short slots or half as many long ones. A new mode is taken up only when the buffer is completely idle.

Top module: `ebuf_manager`

## Requirements
- R1: After reset, out_valid is 0, overflow is 0, mode_active is 0 and every slot is free, so the first accepted trigger takes slot 0.
- R2: An accepted first-level trigger reserves the lowest-numbered free slot. The first stored word is the din value sampled at the 15th rising edge after the edge that captured l1_trig. The following words are the din values of the next consecutive edges until the slot is full.
- R3: While a reserved slot is waiting out its latency or is being filled, l1_lost is high in any cycle in which l1_trig is high. Such a trigger reserves no slot and queues nothing for a second-level decision.
- R4: A first-level trigger taken while no slot is waiting or filling, but with no free slot, is dropped. overflow goes high at that edge and stays high until reset.
- R5: Each l2_valid pulse applies to the oldest undecided slot. l2_keep=1 queues that slot for readout and l2_keep=0 frees it. Kept slots are read out in trigger order.
- R6: During readout, out_slot carries the slot index and out_data carries the slot's words in the order they were written. out_last is high on the final word. All out_* signals hold steady while out_valid is high and out_ready is low.
- R7: Once the final word of a slot has been accepted, that slot is free again and can be reserved by a later trigger.
- R8: mode_sel=0 selects 8 slots of 512 words and mode_sel=1 selects 4 slots of 1024 words. mode_active shows the mode in force. A new mode is applied only on a clock in which all slots are free, no slot is waiting or filling, and l1_trig is low; otherwise the request is ignored.
- R9: An l2_valid pulse while no slot awaits a decision is ignored.
- R10: A kept slot is not offered (out_valid stays 0) until its last word has been written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 1 | Requested geometry: 0 short slots, 1 long slots |
| din | input | DW | Sample stream, one word per clock |
| l1_trig | input | 1 | First-level trigger |
| l2_valid | input | 1 | Second-level decision strobe |
| l2_keep | input | 1 | Decision: 1 keep, 0 discard |
| out_valid | output | 1 | Readout word available |
| out_ready | input | 1 | Readout sink accepts the word |
| out_slot | output | SW | Slot index of the current readout word |
| out_data | output | DW | Readout word |
| out_last | output | 1 | Final word of the slot |
| l1_lost | output | 1 | Trigger arrived while a slot was waiting or filling |
| overflow | output | 1 | Sticky: a trigger found no free slot |
| mode_active | output | 1 | Geometry currently in force |

## Verification
The bench goes after four corner cases.

- **Trigger timing.** A trigger that lands inside another slot's latency window, or during its fill, must be reported lost. A design that opened a second slot here would produce an extra readout slot, and a later keep would then land on the wrong event.
- **Decision timing.** A keep issued before the fill ends must not expose a half-written slot. A second-level strobe with nothing pending must not be remembered and applied to a later event.
- **Overflow and slot reuse.** Overflow must be sticky, and discarded or drained slots must be handed out again lowest-first.
- **Geometry changes.** A change requested while a slot is in use must be refused. A design that accepted it would move the slot base addresses under live data.

Data words carry the free-running sample count, so the expected values follow from the trigger edge alone. An off-by-one in the 15-clock latency shows up as every word shifted by one.

// File: rtl/ebm_pkg.sv
package ebm_pkg;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_WAIT = 2'd1,
    FS_FILL = 2'd2
  } fill_state_t;

  // number of slots in use for a geometry
  function automatic int unsigned slot_count(input logic wide, input int unsigned max_slots);
    return wide ? max_slots / 2 : max_slots;
  endfunction

  // words per slot for a geometry
  function automatic int unsigned slot_len(input logic wide, input int unsigned mem_words,
                                           input int unsigned max_slots);
    return wide ? (2 * mem_words) / max_slots : mem_words / max_slots;
  endfunction

  // first memory address of a slot
  function automatic int unsigned slot_base(input int unsigned idx, input logic wide,
                                            input int unsigned mem_words,
                                            input int unsigned max_slots);
    return idx * slot_len(wide, mem_words, max_slots);
  endfunction

endpackage

// File: rtl/ebm_idx_fifo.sv
module ebm_idx_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 3,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic          empty,
  output logic [CW-1:0] count
);

  logic [W-1:0]  q [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (32'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) q[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign rdata = q[rd_ptr];
  assign empty = (count == '0);

  // R5: decisions and readouts only consume entries that exist
  a_r5_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  a_r5_push_room: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (32'(count) < DEPTH) || pop);

endmodule

// File: rtl/ebm_fill_ctrl.sv
module ebm_fill_ctrl #(
  parameter int MEM_WORDS  = 4096,
  parameter int MAX_SLOTS  = 8,
  parameter int LATENCY    = 15,
  localparam int AW        = $clog2(MEM_WORDS),
  localparam int SW        = $clog2(MAX_SLOTS),
  localparam int DLW       = $clog2(LATENCY + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [SW-1:0] start_slot,
  input  logic          wide,
  output logic          busy,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [SW-1:0] fill_slot
);
  import ebm_pkg::*;

  fill_state_t    st;
  logic [DLW-1:0] dly;
  logic [AW-1:0]  wcnt;
  logic [AW-1:0]  len_m1;
  logic [AW-1:0]  base;

  assign len_m1 = AW'(slot_len(wide, MEM_WORDS, MAX_SLOTS) - 1);
  assign base   = AW'(slot_base(32'(fill_slot), wide, MEM_WORDS, MAX_SLOTS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= FS_IDLE;
      dly       <= '0;
      wcnt      <= '0;
      fill_slot <= '0;
    end else begin
      unique case (st)
        FS_IDLE: if (start) begin
          st        <= FS_WAIT;
          dly       <= DLW'(LATENCY - 1);
          fill_slot <= start_slot;
          wcnt      <= '0;
        end
        FS_WAIT: if (dly == '0) begin
          st   <= FS_FILL;
          wcnt <= AW'(1);
        end else begin
          dly <= dly - 1'b1;
        end
        FS_FILL: if (wcnt == len_m1) begin
          st   <= FS_IDLE;
          wcnt <= '0;
        end else begin
          wcnt <= wcnt + 1'b1;
        end
        default: st <= FS_IDLE;
      endcase
    end
  end

  assign busy  = (st != FS_IDLE);
  assign we    = ((st == FS_WAIT) && (dly == '0)) || (st == FS_FILL);
  assign waddr = base + wcnt;

  // R3: the allocator never starts a second slot while one is in flight
  a_r3_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (st == FS_IDLE));
  // R2: a fill, once started, writes one word on every clock
  a_r2_fill_continuous: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FS_FILL) && (wcnt != len_m1) |=> we);

endmodule

// File: rtl/ebm_event_mem.sv
module ebm_event_mem #(
  parameter int DW    = 10,
  parameter int DEPTH = 4096,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/ebuf_manager.sv
module ebuf_manager #(
  parameter int DW         = 10,
  parameter int MEM_WORDS  = 4096,
  parameter int MAX_SLOTS  = 8,
  parameter int L1_LATENCY = 15,
  localparam int AW        = $clog2(MEM_WORDS),
  localparam int SW        = $clog2(MAX_SLOTS),
  localparam int CW        = $clog2(MAX_SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_sel,
  input  logic [DW-1:0] din,
  input  logic          l1_trig,
  input  logic          l2_valid,
  input  logic          l2_keep,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [SW-1:0] out_slot,
  output logic [DW-1:0] out_data,
  output logic          out_last,
  output logic          l1_lost,
  output logic          overflow,
  output logic          mode_active
);
  import ebm_pkg::*;

  logic                 mode_q;
  logic [MAX_SLOTS-1:0] free_mask, free_nxt, valid_mask, free_avail;
  logic [SW-1:0]        alloc_idx;
  logic                 any_free, alloc_go, drop, all_idle, mode_apply;
  logic                 busy, fill_we;
  logic [AW-1:0]        fill_waddr;
  logic [SW-1:0]        fill_slot;
  logic                 pend_pop, pend_empty, kept_push, kept_pop, kept_empty, discard;
  logic [SW-1:0]        pend_head, kept_head;
  logic [CW-1:0]        pend_cnt, kept_cnt;
  logic [AW-1:0]        rd_cnt, rd_len_m1, raddr;
  logic                 rd_fire;
  int unsigned          nslots;

  assign nslots = slot_count(mode_q, MAX_SLOTS);

  for (genvar g = 0; g < MAX_SLOTS; g++) begin : g_valid
    assign valid_mask[g] = (g < nslots);
  end

  assign free_avail = free_mask & valid_mask;

  // lowest-numbered free slot
  always_comb begin
    alloc_idx = '0;
    any_free  = 1'b0;
    for (int i = MAX_SLOTS - 1; i >= 0; i--) begin
      if (free_avail[i]) begin
        alloc_idx = SW'(i);
        any_free  = 1'b1;
      end
    end
  end

  assign l1_lost    = l1_trig && busy;
  assign alloc_go   = l1_trig && !busy && any_free;
  assign drop       = l1_trig && !busy && !any_free;
  assign all_idle   = ((free_mask | ~valid_mask) == '1) && !busy;
  assign mode_apply = all_idle && !l1_trig && (mode_sel != mode_q);

  // second-level decisions
  assign pend_pop  = l2_valid && !pend_empty;
  assign kept_push = pend_pop && l2_keep;
  assign discard   = pend_pop && !l2_keep;

  // readout
  assign rd_len_m1 = AW'(slot_len(mode_q, MEM_WORDS, MAX_SLOTS) - 1);
  assign raddr     = AW'(slot_base(32'(kept_head), mode_q, MEM_WORDS, MAX_SLOTS)) + rd_cnt;
  assign out_valid = !kept_empty && !(busy && (fill_slot == kept_head));
  assign out_slot  = kept_head;
  assign out_last  = (rd_cnt == rd_len_m1);
  assign rd_fire   = out_valid && out_ready;
  assign kept_pop  = rd_fire && out_last;

  always_comb begin
    free_nxt = free_mask;
    if (alloc_go) free_nxt[alloc_idx] = 1'b0;
    if (discard)  free_nxt[pend_head] = 1'b1;
    if (kept_pop) free_nxt[kept_head] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= 1'b0;
      free_mask <= '1;
      overflow  <= 1'b0;
      rd_cnt    <= '0;
    end else begin
      if (drop) overflow <= 1'b1;
      if (mode_apply) begin
        mode_q    <= mode_sel;
        free_mask <= '1;
      end else begin
        free_mask <= free_nxt;
      end
      if (rd_fire) rd_cnt <= out_last ? '0 : rd_cnt + 1'b1;
    end
  end

  assign mode_active = mode_q;

  ebm_fill_ctrl #(.MEM_WORDS(MEM_WORDS), .MAX_SLOTS(MAX_SLOTS), .LATENCY(L1_LATENCY)) u_fill (
    .clk(clk), .rst_n(rst_n), .start(alloc_go), .start_slot(alloc_idx), .wide(mode_q),
    .busy(busy), .we(fill_we), .waddr(fill_waddr), .fill_slot(fill_slot));

  ebm_event_mem #(.DW(DW), .DEPTH(MEM_WORDS)) u_mem (
    .clk(clk), .we(fill_we), .waddr(fill_waddr), .wdata(din),
    .raddr(raddr), .rdata(out_data));

  ebm_idx_fifo #(.DEPTH(MAX_SLOTS), .W(SW)) u_pend (
    .clk(clk), .rst_n(rst_n), .push(alloc_go), .wdata(alloc_idx), .pop(pend_pop),
    .rdata(pend_head), .empty(pend_empty), .count(pend_cnt));

  ebm_idx_fifo #(.DEPTH(MAX_SLOTS), .W(SW)) u_kept (
    .clk(clk), .rst_n(rst_n), .push(kept_push), .wdata(pend_head), .pop(kept_pop),
    .rdata(kept_head), .empty(kept_empty), .count(kept_cnt));

  // R4: overflow never clears outside reset
  a_r4_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R6: a stalled readout word holds
  a_r6_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_slot) && $stable(out_data)
                                && $stable(out_last));
  // R2: the reserved slot was free and inside the active geometry
  a_r2_alloc_from_free: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_go |-> free_mask[alloc_idx] && valid_mask[alloc_idx]);
  // R8: geometry frozen while anything is in use
  a_r8_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !all_idle |=> $stable(mode_active));
  // R10: the slot being written is never the one offered
  a_r10_no_read_of_filling: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(fill_we && (fill_slot == out_slot)));
  // R5: undecided plus kept slots never exceed the slots in use
  a_r5_queue_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(pend_cnt) + 32'(kept_cnt)) <= nslots);

endmodule

// File: tb/tb_ebuf_manager.sv
`timescale 1ns/1ps
module tb_ebuf_manager;
  localparam int DW  = 10;
  localparam int LAT = 15;
  localparam int SW  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_sel = 1'b0;
  logic [DW-1:0] din;
  logic l1_trig = 1'b0, l2_valid = 1'b0, l2_keep = 1'b0, out_ready = 1'b0;
  logic out_valid, out_last, l1_lost, overflow, mode_active;
  logic [SW-1:0] out_slot;
  logic [DW-1:0] out_data;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (!rst_n) din <= '0;
    else        din <= din + 1'b1;
  end

  ebuf_manager dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .din(din), .l1_trig(l1_trig),
    .l2_valid(l2_valid), .l2_keep(l2_keep), .out_valid(out_valid), .out_ready(out_ready),
    .out_slot(out_slot), .out_data(out_data), .out_last(out_last), .l1_lost(l1_lost),
    .overflow(overflow), .mode_active(mode_active));

  // scenario table: geometry, trigger count, keep pattern, readout stalls
  localparam int NT = 5;
  localparam logic       T_MODE  [NT] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam int         T_N     [NT] = '{2, 3, 2, 4, 1};
  localparam logic [3:0] T_KEEP  [NT] = '{4'b0011, 4'b0101, 4'b0010, 4'b0110, 4'b0000};
  localparam logic       T_STALL [NT] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int len_of(input logic m);
    return m ? 1024 : 512;
  endfunction

  task automatic fire_l1(output int v, input bit exp_lost, input string tag);
    @(negedge clk) l1_trig = 1'b1;
    #1 chk(l1_lost == exp_lost, tag, l1_lost, exp_lost);
    @(posedge clk) v = int'(din);
    @(negedge clk) l1_trig = 1'b0;
  endtask

  task automatic wait_fill(input logic m);
    repeat (LAT + len_of(m) + 2) @(posedge clk);
  endtask

  task automatic l2(input bit keep);
    @(negedge clk) begin l2_valid = 1'b1; l2_keep = keep; end
    @(negedge clk) l2_valid = 1'b0;
  endtask

  task automatic drain(input int slot, input int v, input int len, input bit stall,
                       input string tag);
    for (int k = 0; k < len; k++) begin
      logic [DW-1:0] exp;
      exp = DW'(v + LAT + k);
      if (stall) begin
        @(negedge clk) out_ready = 1'b0;
        #1 chk(out_valid && out_data == exp, tag, out_data, exp);
      end
      @(negedge clk) out_ready = 1'b1;
      #1 chk(out_valid && out_slot == SW'(slot) && out_data == exp &&
             out_last == (k == len - 1), tag, {out_slot, out_data}, {SW'(slot), exp});
    end
    @(negedge clk) out_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int vs [4];
    int v, x;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(!out_valid, "R1 out_valid", out_valid, 0);
    chk(!overflow, "R1 overflow", overflow, 0);
    chk(!mode_active, "R1 mode_active", mode_active, 0);

    // table-driven scenarios
    for (int e = 0; e < NT; e++) begin
      mode_sel = T_MODE[e];
      repeat (2) @(negedge clk);
      #1 chk(mode_active == T_MODE[e], "R8 mode applied", mode_active, T_MODE[e]);
      for (int i = 0; i < T_N[e]; i++) begin
        fire_l1(vs[i], 1'b0, "R3 no lost when idle");
        wait_fill(T_MODE[e]);
      end
      for (int i = 0; i < T_N[e]; i++) l2(T_KEEP[e][i]);
      // R2 slot i belongs to trigger i, R5 kept order, R6 stream, R7 reuse next round
      for (int i = 0; i < T_N[e]; i++)
        if (T_KEEP[e][i]) drain(i, vs[i], len_of(T_MODE[e]), T_STALL[e], "R2/R5/R6 readout");
      @(negedge clk);
      #1 chk(!out_valid, "R5 discarded slots not read", out_valid, 0);
      chk(!overflow, "R4 no overflow", overflow, 0);
    end

    // R3: triggers during latency and during fill are lost
    fire_l1(v, 1'b0, "R3 first trigger");
    repeat (5) @(posedge clk);
    fire_l1(x, 1'b1, "R3 lost in latency");
    repeat (40) @(posedge clk);
    fire_l1(x, 1'b1, "R3 lost in fill");
    wait_fill(1'b0);
    l2(1'b1);
    drain(0, v, 512, 1'b0, "R3 only one slot");
    l2(1'b1);                      // R9: nothing pending
    repeat (3) @(negedge clk);
    #1 chk(!out_valid, "R3 lost trigger queued nothing", out_valid, 0);

    // R9: stray strobe must not apply to the next event
    fire_l1(v, 1'b0, "R9 trigger");
    wait_fill(1'b0);
    @(negedge clk);
    #1 chk(!out_valid, "R9 stray keep ignored", out_valid, 0);
    l2(1'b0);
    @(negedge clk);
    #1 chk(!out_valid, "R5 discard", out_valid, 0);

    // R10: keep decided before fill completes
    fire_l1(v, 1'b0, "R10 trigger");
    repeat (3) @(posedge clk);
    l2(1'b1);
    repeat (100) @(negedge clk);
    #1 chk(!out_valid, "R10 hidden while filling", out_valid, 0);
    wait_fill(1'b0);
    @(negedge clk);
    #1 chk(out_valid && out_slot == 0, "R10 offered after fill", out_valid, 1);
    drain(0, v, 512, 1'b0, "R10 data");

    // R8: change refused while a slot is in use
    fire_l1(v, 1'b0, "R8 trigger");
    @(negedge clk) mode_sel = 1'b1;
    repeat (3) @(negedge clk);
    #1 chk(mode_active == 1'b0, "R8 change ignored", mode_active, 0);
    wait_fill(1'b0);
    l2(1'b0);
    repeat (2) @(negedge clk);
    #1 chk(mode_active == 1'b1, "R8 change when idle", mode_active, 1);

    // R4: overflow in wide geometry, then R7 reuse
    for (int i = 0; i < 4; i++) begin
      fire_l1(vs[i], 1'b0, "R4 fill");
      wait_fill(1'b1);
    end
    fire_l1(x, 1'b0, "R4 fifth trigger");
    #1 chk(overflow, "R4 overflow set", overflow, 1);
    l2(1'b0); l2(1'b1); l2(1'b0); l2(1'b1);
    drain(1, vs[1], 1024, 1'b0, "R5 wide slot 1");
    drain(3, vs[3], 1024, 1'b0, "R5 wide slot 3");
    fire_l1(v, 1'b0, "R7 trigger");
    wait_fill(1'b1);
    l2(1'b1);
    drain(0, v, 1024, 1'b0, "R7 slot 0 reused");
    @(negedge clk);
    #1 chk(overflow, "R4 overflow sticky", overflow, 1);

    // R1: reset clears
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!overflow, "R1 overflow cleared", overflow, 0);
    chk(!mode_active, "R1 mode reset", mode_active, 0);
    chk(!out_valid, "R1 idle output", out_valid, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule